// File: doc/BRIEF.md
# SWD memory access sequencer

This block converts a single target memory read or write into the chain of debug-port and access-port transactions that a two-wire serial debug link needs. A requester presents a 32-bit address, the access-port number and, for a write, a 32-bit data word. The block then drives a downstream transaction engine one transaction at a time and returns one response carrying a status code and, for a successful read, the data.

The target has three quirks that the block hides from the requester:

- **Posted reads.** Access-port reads are posted, so each read request first does a dummy data-register read and then a second read whose result is the real data.
- **Writes need a flush.** Writes only land after eight zero bits are clocked out, so every write ends with a flush transaction.
- **WAIT retries.** WAIT acknowledges are retried automatically, up to a limit that the requester sets.

The block caches the last successfully written select word. It skips the select write when the cached word still matches the request.

Top module: `swd_mem_seq`

## Requirements
- R1: After reset `req_ready_o` is 1, and `rsp_valid_o` and `txn_start_o` are 0.
- R2: A write request issues these transactions in order, then answers with status 1 and data 0:
  - a select write when needed (R4),
  - an access-port write at address bits 2'b01 carrying the memory address,
  - an access-port write at 2'b11 carrying the data,
  - one flush transaction (`txn_flush_o`=1).
- R3: A read request issues these transactions in order, then answers with status 1 and the data returned by the second read:
  - a select write when needed (R4),
  - an access-port write at 2'b01 carrying the address,
  - an access-port read at 2'b11 whose data is discarded,
  - a second access-port read at 2'b11.
- R4: The select write is a debug-port write at address bits 2'b10. Its data word carries the AP number in bits 31:24 and zero elsewhere. It is issued only when no valid cached select word equals the required one. The cache is loaded when a select write is acknowledged OK, and it is emptied by reset or by a fault.
- R5: A WAIT acknowledge (3'b010) reissues the same transaction with identical fields. The sequence moves to the next step only on an OK acknowledge (3'b001).
- R6: When a transaction has already been retried `retry_limit_i` times and gets WAIT again, the response is status 2 with data 0. No further transaction is issued, and the select cache is left unchanged.
- R7: Any acknowledge other than OK or WAIT (for example 3'b100 or 3'b111) ends the request at once with status 4 and data 0, and empties the select cache.
- R8: A read transaction that is acknowledged OK but flags a parity error ends the request with status 8 and data 0. The select cache is kept.
- R9: At most one transaction is outstanding. `txn_start_o` is a one-cycle pulse, and all transaction fields stay unchanged until `txn_done_i`. On a flush transaction the acknowledge is ignored.
- R10: Each accepted request produces exactly one single-cycle `rsp_valid_o` pulse, with a status of exactly one of 1, 2, 4 or 8. `req_ready_o` is 0 from acceptance through the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present; accepted when `req_ready_o` is 1 |
| req_ready_o | output | 1 | Idle and able to accept a request |
| req_write_i | input | 1 | 1 = memory write, 0 = memory read |
| req_apsel_i | input | APSEL_W | Access-port number |
| req_addr_i | input | 32 | Target memory address |
| req_wdata_i | input | 32 | Write data |
| retry_limit_i | input | RETRY_W | Maximum WAIT retries per transaction |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_status_o | output | 4 | 1 OK, 2 WAIT timeout, 4 fault, 8 parity |
| rsp_rdata_o | output | 32 | Read data (0 unless a read succeeds) |
| txn_start_o | output | 1 | Start pulse to the transaction engine |
| txn_flush_o | output | 1 | Transaction is an eight-zero flush |
| txn_ap_o | output | 1 | 1 = access port, 0 = debug port |
| txn_read_o | output | 1 | 1 = read transaction |
| txn_addr_o | output | 2 | Register address bits 3:2 |
| txn_wdata_o | output | 32 | Transaction write data |
| txn_done_i | input | 1 | Transaction finished |
| txn_ack_i | input | 3 | Acknowledge returned by the target |
| txn_perr_i | input | 1 | Parity error on read data |
| txn_rdata_i | input | 32 | Read data from the transaction |

## Verification
The bench builds the block with `RETRY_W` = 3, so the retry limit runs from 0 to 7. This makes both ends reachable in short runs:

- a limit of 0, where the first WAIT times out;
- a limit of 7, with exactly seven WAITs followed by success, so the step is issued eight times.

A bench-side target model posts each data-register read, so the returned word differs from a fresh read. A missing or extra dummy read therefore shows up as wrong data. The model also scripts fault, unknown-acknowledge and parity events, which exercise cache invalidation and cache retention at the ports.

// File: rtl/swd_seq_pkg.sv
package swd_seq_pkg;
  localparam int WORD_W = 32;
  localparam int STS_W  = 4;

  localparam logic [2:0] ACK_OK   = 3'b001;
  localparam logic [2:0] ACK_WAIT = 3'b010;

  localparam logic [STS_W-1:0] STS_OK      = 4'd1;
  localparam logic [STS_W-1:0] STS_TIMEOUT = 4'd2;
  localparam logic [STS_W-1:0] STS_FAULT   = 4'd4;
  localparam logic [STS_W-1:0] STS_PARITY  = 4'd8;

  localparam logic [1:0] DP_SEL_A = 2'b10;
  localparam logic [1:0] AP_TAR_A = 2'b01;
  localparam logic [1:0] AP_DRW_A = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} state_e;

  typedef enum logic [2:0] {
    STEP_SEL, STEP_TAR, STEP_WR, STEP_FLUSH, STEP_DUMMY, STEP_RD
  } step_e;
endpackage

// File: rtl/swd_sel_cache.sv
module swd_sel_cache #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inv_i,
  input  logic [W-1:0] need_i,
  output logic         hit_o
);
  logic         valid_q;
  logic [W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      val_q   <= '0;
    end else if (inv_i) begin
      valid_q <= 1'b0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      val_q   <= load_val_i;
    end
  end

  assign hit_o = valid_q && (val_q == need_i);

  AST_INV_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> !hit_o);  // R7
  AST_LOAD_HITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !inv_i) |=> (valid_q && val_q == $past(load_val_i)));  // R4
endmodule

// File: rtl/swd_retry_ctr.sv
module swd_retry_ctr #(
  parameter int RETRY_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               inc_i,
  input  logic [RETRY_W-1:0] limit_i,
  output logic               exhausted_o
);
  logic [RETRY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign exhausted_o = (cnt_q >= limit_i);

  AST_RETRY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> (cnt_q < limit_i));  // R6
endmodule

// File: rtl/swd_mem_seq.sv
module swd_mem_seq
  import swd_seq_pkg::*;
#(
  parameter int RETRY_W = 8,
  parameter int APSEL_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [APSEL_W-1:0] req_apsel_i,
  input  logic [WORD_W-1:0]  req_addr_i,
  input  logic [WORD_W-1:0]  req_wdata_i,
  input  logic [RETRY_W-1:0] retry_limit_i,
  output logic               rsp_valid_o,
  output logic [STS_W-1:0]   rsp_status_o,
  output logic [WORD_W-1:0]  rsp_rdata_o,
  output logic               txn_start_o,
  output logic               txn_flush_o,
  output logic               txn_ap_o,
  output logic               txn_read_o,
  output logic [1:0]         txn_addr_o,
  output logic [WORD_W-1:0]  txn_wdata_o,
  input  logic               txn_done_i,
  input  logic [2:0]         txn_ack_i,
  input  logic               txn_perr_i,
  input  logic [WORD_W-1:0]  txn_rdata_i
);
  localparam int SEL_LSB = WORD_W - APSEL_W;

  state_e state_q, state_d;
  step_e  step_q, step_d, step_succ;
  logic              wr_q;
  logic [WORD_W-1:0] addr_q, wdata_q, sel_q, rdata_q, need_sel;
  logic [STS_W-1:0]  sts_q, sts_d;
  logic accept, advance, inc, inv, load, set_rsp, cap_rdata, is_rd, hit, exhausted;

  assign need_sel = {req_apsel_i, {SEL_LSB{1'b0}}};
  assign accept   = req_valid_i && (state_q == S_IDLE);
  assign is_rd    = (step_q == STEP_DUMMY) || (step_q == STEP_RD);

  swd_sel_cache #(.W(WORD_W)) u_cache (
    .clk_i, .rst_ni,
    .load_i(load), .load_val_i(sel_q), .inv_i(inv),
    .need_i(need_sel), .hit_o(hit)
  );

  swd_retry_ctr #(.RETRY_W(RETRY_W)) u_retry (
    .clk_i, .rst_ni,
    .clr_i(accept || advance), .inc_i(inc),
    .limit_i(retry_limit_i), .exhausted_o(exhausted)
  );

  always_comb begin
    unique case (step_q)
      STEP_SEL:   step_succ = STEP_TAR;
      STEP_TAR:   step_succ = wr_q ? STEP_WR : STEP_DUMMY;
      STEP_WR:    step_succ = STEP_FLUSH;
      STEP_DUMMY: step_succ = STEP_RD;
      default:    step_succ = STEP_RD;
    endcase
  end

  always_comb begin
    state_d = state_q; step_d = step_q; sts_d = STS_OK;
    advance = 1'b0; inc = 1'b0; inv = 1'b0; load = 1'b0;
    set_rsp = 1'b0; cap_rdata = 1'b0;
    unique case (state_q)
      S_IDLE: if (req_valid_i) begin
        state_d = S_ISSUE;
        step_d  = hit ? STEP_TAR : STEP_SEL;
      end
      S_ISSUE: state_d = S_WAIT;
      S_WAIT: if (txn_done_i) begin
        if (step_q == STEP_FLUSH) begin
          state_d = S_RESP; set_rsp = 1'b1;  // ack not checked on flush
        end else if (txn_ack_i == ACK_OK) begin
          if (is_rd && txn_perr_i) begin
            state_d = S_RESP; set_rsp = 1'b1; sts_d = STS_PARITY;
          end else if (step_q == STEP_RD) begin
            state_d = S_RESP; set_rsp = 1'b1; cap_rdata = 1'b1;
          end else begin
            state_d = S_ISSUE; advance = 1'b1; step_d = step_succ;
            load = (step_q == STEP_SEL);
          end
        end else if (txn_ack_i == ACK_WAIT) begin
          if (exhausted) begin
            state_d = S_RESP; set_rsp = 1'b1; sts_d = STS_TIMEOUT;
          end else begin
            state_d = S_ISSUE; inc = 1'b1;
          end
        end else begin
          state_d = S_RESP; set_rsp = 1'b1; sts_d = STS_FAULT; inv = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      step_q  <= STEP_SEL;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      sel_q   <= '0;
      sts_q   <= STS_OK;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      if (accept) begin
        wr_q    <= req_write_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        sel_q   <= need_sel;
        rdata_q <= '0;
      end
      if (set_rsp)   sts_q   <= sts_d;
      if (cap_rdata) rdata_q <= txn_rdata_i;
    end
  end

  always_comb begin
    txn_flush_o = 1'b0; txn_ap_o = 1'b1; txn_read_o = 1'b0;
    txn_addr_o  = AP_DRW_A; txn_wdata_o = '0;
    unique case (step_q)
      STEP_SEL:   begin txn_ap_o = 1'b0; txn_addr_o = DP_SEL_A; txn_wdata_o = sel_q; end
      STEP_TAR:   begin txn_addr_o = AP_TAR_A; txn_wdata_o = addr_q; end
      STEP_WR:    txn_wdata_o = wdata_q;
      STEP_FLUSH: begin txn_flush_o = 1'b1; txn_ap_o = 1'b0; txn_addr_o = 2'b00; end
      default:    txn_read_o = 1'b1;
    endcase
  end

  assign txn_start_o  = (state_q == S_ISSUE);
  assign req_ready_o  = (state_q == S_IDLE);
  assign rsp_valid_o  = (state_q == S_RESP);
  assign rsp_status_o = sts_q;
  assign rsp_rdata_o  = rdata_q;

  AST_ONE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_start_o |=> !txn_start_o);  // R9
  AST_FIELDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && !txn_done_i) |=>
      $stable({txn_flush_o, txn_ap_o, txn_read_o, txn_addr_o, txn_wdata_o}));  // R9
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));  // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_start_o || rsp_valid_o) |-> !req_ready_o);  // R10
  AST_STATUS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($countones(rsp_status_o) == 1));  // R10
  AST_ERR_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o != STS_OK) |-> (rsp_rdata_o == '0));  // R6
  AST_FAULT_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && txn_done_i && !txn_flush_o && txn_ack_i != ACK_OK
     && txn_ack_i != ACK_WAIT) |=> (rsp_valid_o && rsp_status_o == STS_FAULT));  // R7
endmodule

// File: tb/tb_swd_mem_seq.sv
module tb_swd_mem_seq;
  localparam int RW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_apsel = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [RW-1:0] limit = '0;
  logic req_ready, rsp_valid;
  logic [3:0] rsp_status;
  logic [31:0] rsp_rdata;
  logic txn_start, txn_flush, txn_ap, txn_read;
  logic [1:0] txn_addr;
  logic [31:0] txn_wdata;
  logic txn_done = 1'b0;
  logic [2:0] txn_ack = 3'b001;
  logic txn_perr = 1'b0;
  logic [31:0] txn_rdata = '0;

  swd_mem_seq #(.RETRY_W(RW), .APSEL_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_apsel_i(req_apsel), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .retry_limit_i(limit),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .rsp_rdata_o(rsp_rdata),
    .txn_start_o(txn_start), .txn_flush_o(txn_flush), .txn_ap_o(txn_ap),
    .txn_read_o(txn_read), .txn_addr_o(txn_addr), .txn_wdata_o(txn_wdata),
    .txn_done_i(txn_done), .txn_ack_i(txn_ack), .txn_perr_i(txn_perr),
    .txn_rdata_i(txn_rdata)
  );

  int n_chk = 0, n_fail = 0;
  logic [3:0]  ackq[$];
  logic [36:0] logq[$], expq[$];
  logic [36:0] cur;
  logic [31:0] tar_m = '0, post_m = '0;
  logic pend = 1'b0, r9_err = 1'b0;
  int lat = 0;

  function automatic logic [36:0] ent(logic fl, logic ap, logic rd, logic [1:0] a, logic [31:0] wd);
    return {fl, ap, rd, a, wd};
  endfunction
  function automatic logic [31:0] mem_f(logic [31:0] a);
    return a ^ 32'h5A5A_C3C3;
  endfunction
  function automatic logic [36:0] sel_e(logic [7:0] ap);
    return ent(1'b0, 1'b0, 1'b0, 2'b10, {ap, 24'h0});
  endfunction
  function automatic logic [36:0] tar_e(logic [31:0] a);
    return ent(1'b0, 1'b1, 1'b0, 2'b01, a);
  endfunction
  function automatic logic [36:0] wr_e(logic [31:0] d);
    return ent(1'b0, 1'b1, 1'b0, 2'b11, d);
  endfunction
  function automatic logic [36:0] rd_e();
    return ent(1'b0, 1'b1, 1'b1, 2'b11, 32'h0);
  endfunction
  function automatic logic [36:0] fl_e();
    return ent(1'b1, 1'b0, 1'b0, 2'b00, 32'h0);
  endfunction

  // target model: fixed latency, scripted acks, posted data-register reads
  always @(negedge clk) begin
    logic [3:0] a;
    txn_done = 1'b0;
    if (pend) begin
      if ({txn_flush, txn_ap, txn_read, txn_addr, txn_wdata} != cur) r9_err = 1'b1;
      lat--;
      if (lat == 0) begin
        pend = 1'b0;
        a = (ackq.size() > 0) ? ackq.pop_front() : 4'b0001;
        txn_ack = a[2:0]; txn_perr = a[3]; txn_rdata = '0; txn_done = 1'b1;
        if (a[2:0] == 3'b001 && !cur[36] && cur[35]) begin
          if (!cur[34] && cur[33:32] == 2'b01) tar_m = cur[31:0];
          if (cur[34] && cur[33:32] == 2'b11) begin
            txn_rdata = post_m; post_m = mem_f(tar_m);
          end
        end
      end
    end
    if (txn_start) begin
      if (pend) r9_err = 1'b1;
      cur = {txn_flush, txn_ap, txn_read, txn_addr, txn_wdata};
      logq.push_back(cur);
      pend = 1'b1; lat = 2;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_seq(string req);
    n_chk++;
    if (logq.size() != expq.size()) begin
      n_fail++;
      $display("FAIL %s: actual %0d txns expected %0d", req, logq.size(), expq.size());
    end else begin
      for (int i = 0; i < expq.size(); i++) begin
        if (logq[i] !== expq[i]) begin
          n_fail++;
          $display("FAIL %s: txn %0d actual %h expected %h", req, i, logq[i], expq[i]);
          break;
        end
      end
    end
  endtask

  task automatic do_req(logic wr, logic [7:0] ap, logic [31:0] ad, logic [31:0] wd,
                        logic [RW-1:0] lim, output logic [3:0] sts, output logic [31:0] rd);
    int t;
    logic rdy_err;
    logq.delete();
    @(negedge clk);
    limit = lim; req_write = wr; req_apsel = ap; req_addr = ad; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0; rdy_err = 1'b0;
    while (!rsp_valid && t < 2000) begin
      if (req_ready) rdy_err = 1'b1;
      @(negedge clk);
      t++;
    end
    if (t >= 2000) begin
      n_chk++; n_fail++;
      $display("FAIL R10: no response, actual none expected pulse");
    end
    if (req_ready) rdy_err = 1'b1;
    sts = rsp_status; rd = rsp_rdata;
    @(negedge clk);
    chk("R10 ready/pulse", {62'h0, rdy_err, rsp_valid}, 64'h0);
    chk("R10 ready after rsp", {63'h0, req_ready}, 64'h1);
  endtask

  logic [3:0] s;
  logic [31:0] d;

  initial begin
    #(2_000_000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #12;
    chk("R1 reset outputs", {61'h0, req_ready, rsp_valid, txn_start}, 64'h4);
    #20 rst_n = 1'b1;

    // write, cold cache -> select written
    expq = '{sel_e(8'h00), tar_e(32'h2000_0010), wr_e(32'hDEAD_BEEF), fl_e()};
    do_req(1'b1, 8'h00, 32'h2000_0010, 32'hDEAD_BEEF, 3'd3, s, d);
    chk_seq("R2 write sequence");
    chk("R2 status", {60'h0, s}, 64'h1);
    chk("R2 data", {32'h0, d}, 64'h0);

    // read, same AP -> no select, dummy read first
    expq = '{tar_e(32'h2000_0040), rd_e(), rd_e()};
    do_req(1'b0, 8'h00, 32'h2000_0040, 32'h0, 3'd3, s, d);
    chk_seq("R3 R4 read sequence, select skipped");
    chk("R3 status", {60'h0, s}, 64'h1);
    chk("R3 read data", {32'h0, d}, {32'h0, mem_f(32'h2000_0040)});

    // different AP -> select rewritten
    expq = '{sel_e(8'h03), tar_e(32'h0000_1000), rd_e(), rd_e()};
    do_req(1'b0, 8'h03, 32'h0000_1000, 32'h0, 3'd3, s, d);
    chk_seq("R4 new AP select");
    chk("R4 read data", {32'h0, d}, {32'h0, mem_f(32'h0000_1000)});

    // limit 7, seven WAITs on TAR then OK
    for (int i = 0; i < 7; i++) ackq.push_back(4'b0010);
    expq = '{};
    for (int i = 0; i < 8; i++) expq.push_back(tar_e(32'h0000_2000));
    expq.push_back(wr_e(32'h1234_5678)); expq.push_back(fl_e());
    do_req(1'b1, 8'h03, 32'h0000_2000, 32'h1234_5678, 3'd7, s, d);
    chk_seq("R5 WAIT reissue at max limit");
    chk("R5 status", {60'h0, s}, 64'h1);

    // limit 2, WAIT forever -> timeout after 3 issues
    for (int i = 0; i < 3; i++) ackq.push_back(4'b0010);
    expq = '{tar_e(32'h0000_3000), tar_e(32'h0000_3000), tar_e(32'h0000_3000)};
    do_req(1'b0, 8'h03, 32'h0000_3000, 32'h0, 3'd2, s, d);
    chk_seq("R6 timeout sequence");
    chk("R6 status", {60'h0, s}, 64'h2);
    chk("R6 data", {32'h0, d}, 64'h0);

    // limit 0, single WAIT on data write -> immediate timeout, no flush
    ackq.push_back(4'b0001); ackq.push_back(4'b0010);
    expq = '{tar_e(32'h0000_4000), wr_e(32'h0000_00AA)};
    do_req(1'b1, 8'h03, 32'h0000_4000, 32'h0000_00AA, 3'd0, s, d);
    chk_seq("R6 limit zero, cache kept");
    chk("R6 limit zero status", {60'h0, s}, 64'h2);

    // FAULT on data write
    ackq.push_back(4'b0001); ackq.push_back(4'b0100);
    expq = '{tar_e(32'h0000_5000), wr_e(32'h0000_0055)};
    do_req(1'b1, 8'h03, 32'h0000_5000, 32'h0000_0055, 3'd3, s, d);
    chk_seq("R7 fault stops sequence");
    chk("R7 fault status", {60'h0, s}, 64'h4);

    // after fault the select is rewritten
    expq = '{sel_e(8'h03), tar_e(32'h0000_6000), wr_e(32'h0000_0066), fl_e()};
    do_req(1'b1, 8'h03, 32'h0000_6000, 32'h0000_0066, 3'd3, s, d);
    chk_seq("R7 cache emptied by fault");
    chk("R7 status after recovery", {60'h0, s}, 64'h1);

    // unknown ack on TAR
    ackq.push_back(4'b0111);
    expq = '{tar_e(32'h0000_7000)};
    do_req(1'b0, 8'h03, 32'h0000_7000, 32'h0, 3'd3, s, d);
    chk_seq("R7 unknown ack");
    chk("R7 unknown ack status", {60'h0, s}, 64'h4);
    chk("R7 unknown ack data", {32'h0, d}, 64'h0);

    // parity error on final read
    ackq.push_back(4'b0001); ackq.push_back(4'b0001);
    ackq.push_back(4'b0001); ackq.push_back(4'b1001);
    expq = '{sel_e(8'h03), tar_e(32'h0000_8000), rd_e(), rd_e()};
    do_req(1'b0, 8'h03, 32'h0000_8000, 32'h0, 3'd3, s, d);
    chk_seq("R8 parity sequence");
    chk("R8 parity status", {60'h0, s}, 64'h8);
    chk("R8 parity data", {32'h0, d}, 64'h0);

    // parity keeps the cache
    expq = '{tar_e(32'h0000_9000), rd_e(), rd_e()};
    do_req(1'b0, 8'h03, 32'h0000_9000, 32'h0, 3'd3, s, d);
    chk_seq("R8 cache kept after parity");
    chk("R3 read data after parity", {32'h0, d}, {32'h0, mem_f(32'h0000_9000)});

    chk("R9 one outstanding, fields held", {63'h0, r9_err}, 64'h0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule